// File: doc/BRIEF.md
# Dual Periodic Down-Counter Timer

The block holds two independent 32-bit timers that count down once per clock cycle. Both timers sit behind one word-addressed register window. Software programs a timer with a reload value and a control word. The timer then counts down to expiry and flags each expiry in a sticky status bit. When the interrupt is enabled, that status bit also drives the timer's own interrupt line.

A timer runs either periodically or once. In periodic mode it reloads itself at every expiry. In one-shot mode it stops at zero. There are two ways to change the reload value. A foreground write changes it and, while the timer runs, restarts the count from the new value at once. A background write changes it without disturbing the count in progress, so the new period begins at the next reload. Reads are combinational on the same cycle and writes take effect at the clock edge.

Top module: `dual_countdown_timer`

## Requirements
- R1: Word addresses 0 to 5 select timer 0 and addresses 6 to 11 select timer 1. Within each timer the offsets are: 0 live count, 1 reload value, 2 background reload, 3 control, 4 raw status, 5 masked status. Control keeps only bits 2:0 and reads zero above them.
- R2: After reset every register and both counters read zero and both interrupt lines are low.
- R3: A control write with bit 0 (run) set loads the counter from the reload value at that edge. A control write with bit 0 clear freezes the counter at its current value.
- R4: While running, the counter decreases by one each cycle. When it passes from 1 to 0 it expires, and in periodic mode (control bit 1 clear) it takes the reload value at that edge, so the period equals the reload value in cycles.
- R5: In one-shot mode (control bit 1 set) the counter holds at zero after expiry and does not expire again until it is restarted by a control write or a reload write.
- R6: A reload-value write while running restarts the counter with the written value at that edge. The same write while stopped only stores the value.
- R7: A background-reload write stores the value in both the background and the reload registers and leaves the running count untouched. The value is used at the next expiry reload.
- R8: Expiry sets raw status bit 0. Writing 1 to raw status bit 0 clears it and writing 0 leaves it. An expiry on the same edge as a clear wins.
- R9: Masked status bit 0 reads as raw status AND control bit 2 (interrupt enable), and the timer's interrupt line always equals the same AND.
- R10: Writes to the live count and masked status offsets are ignored. Word addresses 12 and above read zero and ignore writes.
- R11: Accesses to one timer never change the other timer's registers or count.
- R12: A running counter that holds 0 stays at 0 and never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | AddrW | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| irq | output | 2 | Interrupt line per timer |

## Verification
The hardest situations to reach are the ones where a register write and an expiry land on the same edge. Examples are clearing raw status just as the counter passes from 1 to 0, a background write in the final cycle of a period, and a control write that stops a counter sitting at 1. The random stimulus keeps reload values between 0 and 23 and makes about a quarter of the cycles writes. Because periods are that short, expiries fall on write cycles often, and a cycle-level reference model in the bench predicts every read and interrupt level. Directed sequences come first and cover the one-shot hold, a zero reload, and the ignored and out-of-range addresses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CntW         = 32;
  localparam int NumTimers    = 2;
  localparam int RegsPerTimer = 6;
  localparam int CtlW         = 3;

  // control bit positions
  localparam int BitRun     = 0;
  localparam int BitOneShot = 1;
  localparam int BitIrqEn   = 2;

  // per-timer register offsets
  localparam int OffCount  = 0;
  localparam int OffReload = 1;
  localparam int OffBgLoad = 2;
  localparam int OffCtrl   = 3;
  localparam int OffRaw    = 4;
  localparam int OffMasked = 5;

  typedef struct packed {
    logic            load;     // restart counter from loadValue this edge
    logic            run;      // counter may advance this edge
    logic            oneShot;
    logic [CntW-1:0] loadValue;
    logic [CntW-1:0] reload;   // value taken on periodic expiry
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int AddrW = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [AddrW-1:0]                 addr,
  input  logic [CntW-1:0]                  wrData,
  input  logic [NumTimers-1:0][CntW-1:0]   cntVec,
  input  logic [NumTimers-1:0]             expireVec,
  output tmrStrobe_t [NumTimers-1:0]       strobeVec,
  output logic [CntW-1:0]                  rdData,
  output logic [NumTimers-1:0]             irq
);
  logic [NumTimers-1:0][CntW-1:0] rdPart;

  for (genvar t = 0; t < NumTimers; t++) begin : g_tmr
    localparam int Base = t * RegsPerTimer;

    logic             sel;
    logic [AddrW-1:0] off;
    logic             wrCtl, wrLoad, wrBg, wrRaw;
    logic [CtlW-1:0]  ctlQ;
    logic [CntW-1:0]  loadQ, bgQ;
    logic             rawQ;
    logic [CntW-1:0]  rdVal;

    assign sel    = (int'(addr) >= Base) && (int'(addr) < Base + RegsPerTimer);
    assign off    = addr - AddrW'(Base);
    assign wrCtl  = wrEn && sel && (off == AddrW'(OffCtrl));
    assign wrLoad = wrEn && sel && (off == AddrW'(OffReload));
    assign wrBg   = wrEn && sel && (off == AddrW'(OffBgLoad));
    assign wrRaw  = wrEn && sel && (off == AddrW'(OffRaw));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctlQ  <= '0;
        loadQ <= '0;
        bgQ   <= '0;
        rawQ  <= 1'b0;
      end else begin
        if (wrCtl) ctlQ <= wrData[CtlW-1:0];
        if (wrLoad) loadQ <= wrData;
        if (wrBg) begin
          bgQ   <= wrData;
          loadQ <= wrData;
        end
        if (expireVec[t])              rawQ <= 1'b1;
        else if (wrRaw && wrData[0])   rawQ <= 1'b0;
      end
    end

    assign strobeVec[t].load      = (wrCtl && wrData[BitRun]) || (wrLoad && ctlQ[BitRun]);
    assign strobeVec[t].run       = ctlQ[BitRun] && !wrCtl;
    assign strobeVec[t].oneShot   = ctlQ[BitOneShot];
    assign strobeVec[t].loadValue = wrLoad ? wrData : loadQ;
    assign strobeVec[t].reload    = loadQ;

    assign irq[t] = rawQ && ctlQ[BitIrqEn];

    always_comb begin
      rdVal = '0;
      case (off)
        AddrW'(OffCount):  rdVal = cntVec[t];
        AddrW'(OffReload): rdVal = loadQ;
        AddrW'(OffBgLoad): rdVal = bgQ;
        AddrW'(OffCtrl):   rdVal = {{(CntW-CtlW){1'b0}}, ctlQ};
        AddrW'(OffRaw):    rdVal = {{(CntW-1){1'b0}}, rawQ};
        AddrW'(OffMasked): rdVal = {{(CntW-1){1'b0}}, rawQ && ctlQ[BitIrqEn]};
        default:           rdVal = '0;
      endcase
    end

    assign rdPart[t] = sel ? rdVal : '0;
  end

  always_comb begin
    rdData = '0;
    for (int t = 0; t < NumTimers; t++) rdData = rdData | rdPart[t];
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  tmrStrobe_t [NumTimers-1:0]     strobeVec,
  output logic [NumTimers-1:0][CntW-1:0] cntVec,
  output logic [NumTimers-1:0]           expireVec
);
  for (genvar t = 0; t < NumTimers; t++) begin : g_cnt
    tmrStrobe_t      s;
    logic [CntW-1:0] cntQ;
    logic            atOne;

    assign s     = strobeVec[t];
    assign atOne = (cntQ == CntW'(1));
    assign expireVec[t] = s.run && !s.load && atOne;
    assign cntVec[t]    = cntQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (s.load) begin
        cntQ <= s.loadValue;
      end else if (s.run && (cntQ != '0)) begin
        if (atOne) cntQ <= s.oneShot ? '0 : s.reload;
        else       cntQ <= cntQ - CntW'(1);
      end
    end
  end
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import tmr_pkg::*;
#(
  parameter int AddrW = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [AddrW-1:0]     addr,
  input  logic [CntW-1:0]      wrData,
  output logic [CntW-1:0]      rdData,
  output logic [NumTimers-1:0] irq
);
  tmrStrobe_t [NumTimers-1:0]     strobeVec;
  logic [NumTimers-1:0][CntW-1:0] cntVec;
  logic [NumTimers-1:0]           expireVec;

  tmr_ctrl #(.AddrW(AddrW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .cntVec    (cntVec),
    .expireVec (expireVec),
    .strobeVec (strobeVec),
    .rdData    (rdData),
    .irq       (irq)
  );

  tmr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobeVec (strobeVec),
    .cntVec    (cntVec),
    .expireVec (expireVec)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int AddrW = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           wrEn,
  input logic [AddrW-1:0]               addr,
  input logic [CntW-1:0]                wrData,
  input logic [CntW-1:0]                rdData,
  input logic [NumTimers-1:0]           irq,
  input logic [NumTimers-1:0][CntW-1:0] cntVec,
  input logic [NumTimers-1:0]           expireVec
);
  for (genvar t = 0; t < NumTimers; t++) begin : g_chk
    localparam int Base = t * RegsPerTimer;

    // R12 / R5: a zero count stays zero without a write
    p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (cntVec[t] == '0 && !wrEn) |=> (cntVec[t] == '0));

    // R4: without writes the count moves down by one, reloads, or holds
    p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!wrEn && cntVec[t] > CntW'(1)) |=>
        (cntVec[t] == $past(cntVec[t]) || cntVec[t] == $past(cntVec[t]) - CntW'(1)));

    // R4: expiry only from a count of one
    p_expire_at_one_r4: assert property (@(posedge clk) disable iff (!rstN)
      expireVec[t] |-> (cntVec[t] == CntW'(1)));

    // R9: masked status read matches the interrupt line
    p_masked_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
      (int'(addr) == Base + OffMasked) |-> (rdData == {{(CntW-1){1'b0}}, irq[t]}));

    // R8: a clear without a competing expiry drops the interrupt
    p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && int'(addr) == Base + OffRaw && wrData[0] && !expireVec[t]) |=> !irq[t]);
  end

  // R10: out-of-range addresses read zero
  p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (int'(addr) >= NumTimers * RegsPerTimer) |-> (rdData == '0));
endmodule

bind dual_countdown_timer tmr_checker #(.AddrW(AddrW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .rdData    (rdData),
  .irq       (irq),
  .cntVec    (cntVec),
  .expireVec (expireVec)
);

// File: tb/dual_countdown_timer_test.sv
`timescale 1ns/1ps
module dual_countdown_timer_test;
  localparam int AddrW = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dual_countdown_timer #(.AddrW(AddrW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // reference model state
  logic [31:0] mCnt [2];
  logic [31:0] mLoad[2];
  logic [31:0] mBg  [2];
  logic [2:0]  mCtl [2];
  logic        mRaw [2];

  task automatic modelReset();
    for (int t = 0; t < 2; t++) begin
      mCnt[t] = 0; mLoad[t] = 0; mBg[t] = 0; mCtl[t] = 0; mRaw[t] = 0;
    end
  endtask

  function automatic logic [31:0] modelRead(int a);
    int t, o;
    if (a >= 12) return 32'd0;
    t = a / 6; o = a % 6;
    case (o)
      0: return mCnt[t];
      1: return mLoad[t];
      2: return mBg[t];
      3: return {29'd0, mCtl[t]};
      4: return {31'd0, mRaw[t]};
      default: return {31'd0, mRaw[t] & mCtl[t][2]};
    endcase
  endfunction

  function automatic logic modelIrq(int t);
    return mRaw[t] & mCtl[t][2];
  endfunction

  // advance model by one clock edge with the given bus inputs
  task automatic modelStep(bit we, int a, logic [31:0] d);
    for (int t = 0; t < 2; t++) begin
      bit hit = we && a >= t*6 && a < t*6 + 6;
      int o = a - t*6;
      bit wCtl = hit && o == 3;
      bit wLd  = hit && o == 1;
      bit wBg  = hit && o == 2;
      bit wRaw = hit && o == 4;
      bit ld   = (wCtl && d[0]) || (wLd && mCtl[t][0]);
      bit run  = mCtl[t][0] && !wCtl;
      bit exp_ = run && !ld && mCnt[t] == 1;
      logic [31:0] nCnt = mCnt[t];
      if (ld) nCnt = wLd ? d : mLoad[t];
      else if (run && mCnt[t] != 0)
        nCnt = (mCnt[t] == 1) ? (mCtl[t][1] ? 32'd0 : mLoad[t]) : mCnt[t] - 1;
      if (exp_) mRaw[t] = 1;
      else if (wRaw && d[0]) mRaw[t] = 0;
      if (wCtl) mCtl[t] = d[2:0];
      if (wLd)  mLoad[t] = d;
      if (wBg) begin mBg[t] = d; mLoad[t] = d; end
      mCnt[t] = nCnt;
    end
  endtask

  function automatic string offTag(int a);
    if (a >= 12) return "R10";
    case (a % 6)
      0: return "R4";
      1: return "R6";
      2: return "R7";
      3: return "R3";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic checkEq(logic [31:0] act, logic [31:0] exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive, compare combinational outputs, advance model
  task automatic cyc(bit we, int a, logic [31:0] d, string tag);
    @(negedge clk);
    wrEn = we; addr = 4'(a); wrData = d;
    #1;
    checkEq(rdData, modelRead(a), tag);
    checkEq({30'd0, irq}, {30'd0, modelIrq(1), modelIrq(0)}, "R9");
    modelStep(we, a, d);
  endtask

  task automatic rd(int a, string tag);
    cyc(0, a, 32'd0, tag);
  endtask

  task automatic wr(int a, logic [31:0] d, string tag);
    cyc(1, a, d, tag);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: reset state everywhere
    for (int a = 0; a < 16; a++) rd(a, "R2");
    @(negedge clk); #1;
    checkEq({30'd0, irq}, 32'd0, "R2");

    // R1: control keeps three bits
    wr(3, 32'hFFFF_FFF8, "R1");
    rd(3, "R1");
    wr(3, 32'd0, "R1");

    // R6 store while stopped, R3 start, R4 periodic counting
    wr(1, 32'd4, "R6");
    rd(0, "R6");
    wr(3, 32'd5, "R3");
    for (int i = 0; i < 10; i++) rd(0, "R4");
    rd(4, "R8");

    // R7 background write mid-period
    wr(2, 32'd7, "R7");
    for (int i = 0; i < 16; i++) rd(0, "R7");
    rd(1, "R7");

    // R6 reload write while running
    wr(1, 32'd3, "R6");
    for (int i = 0; i < 4; i++) rd(0, "R6");

    // R8 clear with zero then one
    wr(4, 32'd0, "R8");
    rd(4, "R8");
    wr(4, 32'd1, "R8");
    rd(4, "R8");

    // R3 stop freezes count; R11 timer 1 untouched
    wr(3, 32'd0, "R3");
    for (int i = 0; i < 3; i++) rd(0, "R3");
    for (int a = 6; a < 12; a++) rd(a, "R11");

    // R5 one-shot on timer 1
    wr(7, 32'd2, "R5");
    wr(9, 32'd7, "R5");
    for (int i = 0; i < 6; i++) rd(6, "R5");
    @(negedge clk); addr = 4'd6; wrEn = 0; #1;
    checkEq(rdData, 32'd0, "R5");
    checkEq({31'd0, irq[1]}, 32'd1, "R5");
    modelStep(0, 6, 0);
    rd(0, "R11");

    // R10 ignored writes
    wr(6, 32'h1234, "R10");
    rd(6, "R10");
    wr(11, 32'd0, "R10");
    rd(11, "R10");
    wr(13, 32'hDEAD_BEEF, "R10");
    rd(13, "R10");
    for (int a = 0; a < 12; a++) rd(a, "R10");

    // R12 zero reload while running
    wr(1, 32'd0, "R12");
    wr(3, 32'd1, "R12");
    wr(4, 32'd1, "R12");
    for (int i = 0; i < 5; i++) rd(0, "R12");
    rd(4, "R12");

    // constrained random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      int a = $urandom % 16;
      bit we = ($urandom % 4) == 0;
      logic [31:0] d;
      case (a % 6)
        1, 2:    d = $urandom % 24;
        3:       d = $urandom % 8;
        4:       d = $urandom % 2;
        default: d = $urandom;
      endcase
      cyc(we, a, d, offTag(a));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule